// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes received Ethernet frames as a byte stream and stores each one in memory. The stream carries a valid strobe, an end-of-frame marker and an error flag. Where each frame goes is set by a ring of descriptors kept in a synchronous memory that is shared with software. Each descriptor gives a buffer address and an ownership bit. The engine copies the frame bytes into that buffer. It then writes the received length and a status word back into the descriptor, and moves on to the next descriptor in the ring.

Software owns a descriptor while its empty bit is clear. To hand a descriptor to the engine, software sets the empty bit and then writes the activate register with bit 24 set. When the engine fetches a descriptor that software still owns, it stalls. While stalled it discards incoming frames and raises an overrun flag, until the next activate write. A wrap bit marks the last descriptor in the ring, and the descriptor after it is the one at the ring start address.

The controller has eight states:

- OFF: the state after reset.
- FETCH_SC: issues the read of the status/length word.
- FETCH_BUF: checks the empty bit and issues the read of the buffer word.
- LOAD: captures the buffer address.
- READY: waits for the first byte of a frame.
- RECV: stores the bytes of a frame.
- WB: writes the descriptor back.
- STALL: waits for an activate write.

The transitions are:

- OFF→FETCH_SC on activate.
- FETCH_SC→FETCH_BUF.
- FETCH_BUF→LOAD when the descriptor is empty.
- FETCH_BUF→STALL when it is not.
- LOAD→READY.
- READY→RECV on the first accepted byte.
- READY→WB on a one-byte frame.
- RECV→WB on end of frame.
- WB→FETCH_SC.
- STALL→FETCH_SC on activate.

Top module: `rx_desc_ring`

## Requirements
- R1: Each descriptor is 8 bytes, and descriptors sit back to back.
  - Word 0 holds status in bits 31:16 and length in bits 15:0.
  - Word 1 holds the buffer byte address.
  - Status bit 15 is the empty bit and status bit 13 is the wrap bit.
  - Status bits 5:0 are error flags. Bit 0 is the frame error and bit 5 is length violation.
- R2: After reset the engine makes no memory access until an activate write with bit 24 set. The first descriptor it then uses is the one at `ring_start`.
- R3: The engine fills a descriptor only while its empty bit is set.
  - On a descriptor that is not empty it stalls. While stalled it writes nothing, drops every incoming byte and sets `overrun`.
  - It stays stalled until an activate write that has bit 24 set. An activate write with bit 24 clear has no effect.
- R4: Byte n of a frame is written to byte address buffer+n. The byte lane is selected by address bits 1:0.
- R5: Write-back puts the full count of received bytes into the length field, including the 4 trailing FCS bytes.
  - It clears the empty bit and keeps status bits 14:6, including the wrap bit.
  - It replaces status bits 5:0 with the new error flags.
- R6: If `rx_err` is high with the end-of-frame byte, status bit 0 is set. Otherwise bit 0 is clear.
- R7: A frame longer than MAX_FRAME (1518) bytes sets status bit 5.
  - Only the first BUF_SIZE (1520) bytes are written.
  - The length field saturates at BUF_SIZE.
  - A frame of exactly 1518 bytes is not flagged.
- R8: After write-back of a descriptor with the wrap bit set, the next descriptor is at `ring_start`. Otherwise it is at the current address plus 8.
- R9: `frame_evt` goes high the cycle after each write-back and stays high until `evt_clr[0]` is pulsed. `evt_clr[1]` clears `overrun`. A new set in the same cycle wins over a clear.
- R10: If a frame's first byte is dropped, the rest of that frame is also dropped up to its end-of-frame byte. This holds even when a descriptor becomes available in the middle of that frame.
- R11: Frames separated by 4 idle cycles are all accepted, each into its own descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_start | input | AW | Byte address of the first descriptor |
| poll_wr | input | 1 | Write strobe for the activate register |
| poll_data | input | 32 | Activate write data; bit 24 requests a descriptor poll |
| evt_clr | input | 2 | Write-1-to-clear: bit 0 clears frame_evt, bit 1 clears overrun |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_err | input | 1 | Frame error, sampled with the last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_be | output | 4 | Byte-lane enables for a write |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| frame_evt | output | 1 | Sticky frame-received event |
| overrun | output | 1 | Sticky dropped-byte flag |

## Verification
The bench targets the ownership boundaries.

- It checks that a stall on a descriptor software still owns writes nothing. A design that ignored the empty bit would overwrite a buffer software still holds.
- It checks that an activate write without bit 24 leaves the engine stalled. A design that woke on any write would take frames into descriptors too early.
- It sends frames of 1518, 1519 and 1525 bytes, with a marker byte just past the written length. A design that was off by one on the saturation or length check would flag the wrong frame or write past the buffer.
- It sends a frame that is cut in half by a mid-frame activate write. A design that did not track the dropped frame would store its tail as a new frame.
- It sends two frames only four idle cycles apart. A design with a longer fetch path would lose the second frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    // Controller states
    typedef enum logic [2:0] {
        S_OFF,
        S_FETCH_SC,
        S_FETCH_BUF,
        S_LOAD,
        S_READY,
        S_RECV,
        S_WB,
        S_STALL
    } rxr_state_e;

    // Bit positions within a descriptor's 32-bit word 0
    localparam int W0_EMPTY   = 31;   // status bit 15
    localparam int W0_WRAP    = 29;   // status bit 13
    localparam int DESC_BYTES = 8;
    localparam int POLL_BIT   = 24;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int AW   = 16,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          wrap,
    input  logic [AW-1:0] start,
    output logic [AW-1:0] cur
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (load || (advance && wrap))
            cur <= start;
        else if (advance)
            cur <= cur + AW'(STEP);
    end

    // R8: wrap returns the pointer to the ring start
    a_r8_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap && !load) |=> (cur == $past(start)));
    // R8: otherwise the pointer steps by one descriptor
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wrap && !load) |=> (cur == $past(cur) + AW'(STEP)));
endmodule

// File: rtl/rxr_len_ctr.sv
module rxr_len_ctr #(
    parameter int LW        = 16,
    parameter int BUF_SIZE  = 1520,
    parameter int MAX_FRAME = 1518
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [LW-1:0] cnt,
    output logic          full,
    output logic          over
);
    localparam logic [LW-1:0] CAP = LW'(BUF_SIZE);
    localparam logic [LW-1:0] LIM = LW'(MAX_FRAME);

    assign full = (cnt == CAP);
    assign over = (cnt > LIM);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && !full)
            cnt <= cnt + LW'(1);
    end

    // R7: the count never passes the buffer size
    a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CAP);
endmodule

// File: rtl/rxr_flags.sv
module rxr_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_evt,
    input  logic       set_ovr,
    input  logic [1:0] clr,
    output logic       evt,
    output logic       ovr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt <= 1'b0;
            ovr <= 1'b0;
        end else begin
            evt <= set_evt | (evt & ~clr[0]);
            ovr <= set_ovr | (ovr & ~clr[1]);
        end
    end

    // R9: a clear with no simultaneous set lowers the flag
    a_r9_evt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !set_evt) |=> !evt);
    a_r9_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[1] && !set_ovr) |=> !ovr);
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
    import rxr_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LW        = 16,
    parameter int BUF_SIZE  = 1520,
    parameter int MAX_FRAME = 1518
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_start,
    input  logic          poll_wr,
    input  logic [31:0]   poll_data,
    input  logic [1:0]    evt_clr,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_eof,
    input  logic          rx_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          frame_evt,
    output logic          overrun
);
    localparam int KEEP_W = 9;   // status bits 14:6 kept on write-back

    rxr_state_e        state, nxt;
    logic [KEEP_W-1:0] keep_q;
    logic [AW-1:0]     buf_q;
    logic              skip_q, err_q;
    logic [AW-1:0]     cur;
    logic [LW-1:0]     cnt;
    logic              full, over;
    logic              poll_go, accept, take, drop;
    logic [AW-1:0]     byte_addr;
    logic              unused_bits;

    assign unused_bits = ^{mem_rdata, poll_data};
    assign poll_go     = poll_wr && poll_data[POLL_BIT];
    assign accept      = (state == S_RECV) || (state == S_READY && !skip_q);
    assign take        = rx_valid && accept;
    assign drop        = rx_valid && !accept;
    assign byte_addr   = buf_q + AW'(cnt);

    rxr_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(state == S_OFF && poll_go),
        .advance(state == S_WB),
        .wrap(keep_q[W0_WRAP-22]),
        .start(ring_start),
        .cur(cur)
    );

    rxr_len_ctr #(.LW(LW), .BUF_SIZE(BUF_SIZE), .MAX_FRAME(MAX_FRAME)) u_len (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_LOAD),
        .inc(take),
        .cnt(cnt), .full(full), .over(over)
    );

    rxr_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_evt(state == S_WB),
        .set_ovr(drop),
        .clr(evt_clr),
        .evt(frame_evt), .ovr(overrun)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:       if (poll_go) nxt = S_FETCH_SC;
            S_FETCH_SC:  nxt = S_FETCH_BUF;
            S_FETCH_BUF: nxt = mem_rdata[W0_EMPTY] ? S_LOAD : S_STALL;
            S_LOAD:      nxt = S_READY;
            S_READY:     if (take) nxt = rx_eof ? S_WB : S_RECV;
            S_RECV:      if (take && rx_eof) nxt = S_WB;
            S_WB:        nxt = S_FETCH_SC;
            S_STALL:     if (poll_go) nxt = S_FETCH_SC;
            default:     nxt = S_OFF;
        endcase
    end

    // Descriptor fields and per-frame flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '0;
            buf_q  <= '0;
            skip_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (state == S_FETCH_BUF) keep_q <= mem_rdata[30:22];
            if (state == S_LOAD)      buf_q  <= mem_rdata[AW-1:0];
            if (drop)                 skip_q <= !rx_eof;
            if (take && rx_eof)       err_q  <= rx_err;
        end
    end

    // Memory port outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_be    = 4'h0;
        mem_wdata = '0;
        unique case (state)
            S_FETCH_SC: mem_req = 1'b1;
            S_FETCH_BUF: begin
                mem_req  = mem_rdata[W0_EMPTY];
                mem_addr = cur + AW'(4);
            end
            S_READY, S_RECV: begin
                if (take && !full) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = byte_addr;
                    mem_be    = 4'b0001 << byte_addr[1:0];
                    mem_wdata = {4{rx_data}};
                end
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_wdata = {1'b0, keep_q, over, 4'b0000, err_q, cnt};
            end
            default: ;
        endcase
    end

    // R7: a byte write never lands at or past the buffer size
    a_r7_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> (cnt < LW'(BUF_SIZE)));
    // R5: write-back hands the descriptor to software and keeps the wrap bit
    a_r5_wb_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'hF) |->
            (!mem_wdata[W0_EMPTY] && mem_wdata[W0_WRAP] == keep_q[W0_WRAP-22]));
    // R3: a byte seen while stalled raises overrun
    a_r3_stall_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && state == S_STALL) |=> overrun);
    // R9: the frame event only rises after a write-back
    a_r9_evt_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_evt) |-> ($past(state) == S_WB));
    // R2: no memory access while still off
    a_r2_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF) |-> !mem_req);
endmodule

// File: tb/rx_desc_ring_bench.sv
module rx_desc_ring_bench;
    localparam int AW    = 16;
    localparam int RING  = 'h100;
    localparam int NV    = 6;
    localparam int V_LEN [NV] = '{64, 60, 1518, 1519, 1525, 1};
    localparam int V_ERR [NV] = '{0, 1, 0, 0, 0, 1};
    localparam int V_XLEN[NV] = '{64, 60, 1518, 1519, 1520, 1};
    localparam int V_XERR[NV] = '{0, 1, 0, 32, 32, 1};
    localparam int BUFS  [3]  = '{'h1000, 'h1800, 'h2000};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ring_start = AW'(RING);
    logic          poll_wr = 1'b0;
    logic [31:0]   poll_data = '0;
    logic [1:0]    evt_clr = '0;
    logic          rx_valid = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          frame_evt, overrun;

    int  checks = 0, fails = 0, req_cnt = 0;
    bit  done = 1'b0;

    logic [31:0] mem [0:4095];
    logic        sw_we = 1'b0;
    logic [11:0] sw_idx = '0;
    logic [31:0] sw_data = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    rx_desc_ring u_rx_desc_ring (
        .clk(clk), .rst_n(rst_n), .ring_start(ring_start),
        .poll_wr(poll_wr), .poll_data(poll_data), .evt_clr(evt_clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .frame_evt(frame_evt), .overrun(overrun)
    );

    // Memory model: engine port plus a bench-side write port
    always @(posedge clk) begin
        if (sw_we) mem[sw_idx] <= sw_data;
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[13:2]];
            end
        end
        if (rst_n && mem_req) req_cnt <= req_cnt + 1;
    end

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((k * 7 + seed) & 255);
    endfunction

    function automatic logic [7:0] rd_byte(int a);
        return mem[a[13:2]][8*a[1:0] +: 8];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input int a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_idx = a[13:2]; sw_data = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic poll(input logic [31:0] d);
        @(negedge clk);
        poll_wr = 1'b1; poll_data = d;
        @(negedge clk);
        poll_wr = 1'b0; poll_data = '0;
    endtask

    task automatic clear(input logic [1:0] m);
        @(negedge clk);
        evt_clr = m;
        @(negedge clk);
        evt_clr = '0;
    endtask

    task automatic send_bytes(input int n, input bit eof, input bit err,
                              input int seed, input int start);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pat(seed, start + k);
            rx_eof   = eof && (k == n - 1);
            rx_err   = err && eof && (k == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    endtask

    // R1: word0 with empty bit, wrap bit on the last descriptor
    task automatic rearm(input int d);
        sw_write(RING + 8*d, (d == 2) ? 32'hA000_0000 : 32'h8000_0000);
    endtask

    task automatic check_desc(input int d, input int xlen, input int xerr,
                              input int seed, input string tag);
        logic [31:0] w0;
        int bad;
        w0 = mem[(RING + 8*d) >> 2];
        chk(w0[15:0] == 16'(xlen), {tag, " R5 length"}, int'(w0[15:0]), xlen);
        chk(w0[21:16] == 6'(xerr), {tag, " R6 error bits"}, int'(w0[21:16]), xerr);
        chk(w0[31] == 1'b0, {tag, " R1 empty cleared"}, int'(w0[31]), 0);
        chk(w0[29] == (d == 2), {tag, " R8 wrap kept"}, int'(w0[29]), int'(d == 2));
        bad = 0;
        for (int k = 0; k < xlen; k++)
            if (rd_byte(BUFS[d] + k) !== pat(seed, k)) bad++;
        chk(bad == 0, {tag, " R4 payload"}, bad, 0);
        chk(rd_byte(BUFS[d] + xlen) == 8'hEE, {tag, " R7 no write past end"},
            int'(rd_byte(BUFS[d] + xlen)), 'hEE);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 3; d++) begin
            sw_write(RING + 8*d + 4, 32'(BUFS[d]));
            rearm(d);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // R2: reset state and silence
        chk(frame_evt == 1'b0, "R2 reset frame_evt", int'(frame_evt), 0);
        chk(overrun == 1'b0, "R2 reset overrun", int'(overrun), 0);
        poll(32'h0080_0000);
        repeat (5) @(negedge clk);
        chk(req_cnt == 0, "R2 no access before activate", req_cnt, 0);
        poll(32'h0100_0000);
        repeat (6) @(negedge clk);
        chk(req_cnt == 2, "R2 fetch of first descriptor", req_cnt, 2);

        // Table of frames walked through the ring
        for (int i = 0; i < NV; i++) begin
            int d;
            d = i % 3;
            sw_write(BUFS[d] + V_XLEN[i], 32'hEEEE_EEEE);
            send_bytes(V_LEN[i], 1'b1, V_ERR[i] != 0, 17 * i, 0);
            repeat (4) @(negedge clk);
            check_desc(d, V_XLEN[i], V_XERR[i], 17 * i, $sformatf("vec%0d", i));
            chk(frame_evt == 1'b1, "R9 event set", int'(frame_evt), 1);
            clear(2'b01);
            chk(frame_evt == 1'b0, "R9 event cleared", int'(frame_evt), 0);
            rearm(d);
        end

        // R11: two frames with four idle cycles between them
        sw_write(BUFS[0] + 20, 32'hEEEE_EEEE);
        sw_write(BUFS[1] + 30, 32'hEEEE_EEEE);
        send_bytes(20, 1'b1, 1'b0, 3, 0);
        repeat (3) @(negedge clk);
        send_bytes(30, 1'b1, 1'b0, 5, 0);
        repeat (6) @(negedge clk);
        check_desc(0, 20, 0, 3, "R11 first");
        check_desc(1, 30, 0, 5, "R11 second");

        // R3: stall on an owned descriptor (d0, d1 now belong to software)
        sw_write(BUFS[2] + 16, 32'hEEEE_EEEE);
        send_bytes(16, 1'b1, 1'b0, 9, 0);
        repeat (8) @(negedge clk);
        check_desc(2, 16, 0, 9, "R3 pre-stall");
        clear(2'b11);
        sw_write(BUFS[0], 32'hEEEE_EEEE);
        send_bytes(20, 1'b1, 1'b0, 11, 0);
        repeat (3) @(negedge clk);
        chk(overrun == 1'b1, "R3 overrun on stall", int'(overrun), 1);
        chk(rd_byte(BUFS[0]) == 8'hEE, "R3 no buffer write", int'(rd_byte(BUFS[0])), 'hEE);
        chk(mem[RING >> 2][15:0] == 16'd20, "R3 descriptor untouched",
            int'(mem[RING >> 2][15:0]), 20);
        rearm(0);
        poll(32'hFEFF_FFFF);
        repeat (4) @(negedge clk);
        send_bytes(10, 1'b1, 1'b0, 13, 0);
        repeat (4) @(negedge clk);
        chk(mem[RING >> 2] == 32'h8000_0000, "R3 activate without bit 24 ignored",
            int'(mem[RING >> 2]), 32'h8000_0000);
        poll(32'h0100_0000);
        repeat (6) @(negedge clk);
        sw_write(BUFS[0] + 24, 32'hEEEE_EEEE);
        send_bytes(24, 1'b1, 1'b0, 15, 0);
        repeat (4) @(negedge clk);
        check_desc(0, 24, 0, 15, "R3 resumed");
        chk(overrun == 1'b1, "R9 overrun sticky", int'(overrun), 1);
        clear(2'b10);
        chk(overrun == 1'b0, "R9 overrun cleared", int'(overrun), 0);

        // R10: frame split by an activate arriving mid-frame (d1 is owned)
        send_bytes(5, 1'b0, 1'b0, 21, 0);
        rearm(1);
        poll(32'h0100_0000);
        repeat (8) @(negedge clk);
        send_bytes(5, 1'b1, 1'b0, 21, 5);
        repeat (4) @(negedge clk);
        chk(mem[(RING + 8) >> 2] == 32'h8000_0000, "R10 tail of dropped frame discarded",
            int'(mem[(RING + 8) >> 2]), 32'h8000_0000);
        sw_write(BUFS[1] + 12, 32'hEEEE_EEEE);
        send_bytes(12, 1'b1, 1'b0, 23, 0);
        repeat (4) @(negedge clk);
        check_desc(1, 12, 0, 23, "R10 next frame");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule